// File: doc/BRIEF.md
# Exception Stack Frame Save/Restore Sequencer

This block saves processor state to memory when an exception is taken and restores it when the handler returns. On an entry request it captures the current stack pointer and eight register values. It writes them as one 32-byte frame just below that stack pointer, one word per cycle. It then reports the lowered stack pointer and places a return token in the link register output. Because the token travels in the link register, a handler written as an ordinary function needs no wrapper code. A later ordinary return to that token value triggers the restore.

On a return request the block checks the branch target. If the top four bits of the target are all ones, the target is the token: the block reads the eight words back in ascending address order, drives them on the restored-register outputs and reports the stack pointer raised by 32. Any other target is an ordinary return, and the block ignores it.

The memory side is a single-cycle word port. A write or read is accepted in any cycle in which `mem_ready` is high. Read data must be valid in the same cycle as the read.

Top module: `exc_frame_engine`

## Requirements
- R1: An accepted entry request performs exactly eight word writes. Slot s of `regs_in` is the value written to slot s of the frame, with slots 0..7 being r0, r1, r2, r3, r12, r14, return address, xPSR.
- R2: Frame slot s is stored at address (sp_in - 32) + 4*s. Slot 0 (r0) is at the lowest address and slot 7 (xPSR) is at the highest.
- R3: Entry writes go in descending address order: xPSR first, then the return address, and so on down to r0. The next write is issued in the cycle after the previous one is accepted. The first write, at sp_in - 4, appears in the cycle after the request.
- R4: With `mem_ready` held high, `done` rises in the ninth clock edge counted from the edge that samples the entry request. At that point `sp_out` equals sp_in - 32 and `lr_out` equals 0xFFFFFFF9.
- R5: A return request whose target has bits [31:28] all ones performs eight reads from sp_in upward, r0 first. Slot s of `regs_out` then holds the word read at sp_in + 4*s, `sp_out` becomes sp_in + 32 and `done` pulses.
- R6: A return request whose target does not have bits [31:28] all ones causes no memory access. It also leaves `busy`, `done`, `sp_out` and `regs_out` unchanged.
- R7: An entry request, or a token return request, with sp_in[1:0] not zero starts no access. It raises `align_err` for exactly the following cycle and leaves `sp_out` unchanged.
- R8: `busy` is high from the cycle after an accepted request until the cycle after the last accepted access. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R9: Requests that arrive while `busy` is high are ignored. If an entry request and a token return request arrive in the same idle cycle, the entry is performed and the return is dropped.
- R10: Each cycle with an access pending and `mem_ready` low delays the sequence by one cycle. The address, data and direction are held during that cycle, and the order and values are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 1 | Request to save a frame |
| ret_req | input | 1 | Return request with branch target |
| ret_target | input | 32 | Branch target of the return |
| sp_in | input | 32 | Current stack pointer |
| regs_in | input | 8x32 | Register values to save, slot 0..7 |
| regs_out | output | 8x32 | Restored register values, slot 0..7 |
| sp_out | output | 32 | Updated stack pointer |
| lr_out | output | 32 | Link register value loaded on entry |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | Unaligned stack pointer on a request |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Word address (byte units) |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the read cycle |
| mem_ready | input | 1 | Access accepted this cycle |

## Verification
The bench provokes two clashes. In the first, an entry request and a token return arrive in the same idle cycle. The bench judges the outcome from the memory log: eight writes and no read must appear. In the second, new entry and token return requests are raised in the middle of a sequence. The completed frame, the access count and `sp_out` must show no trace of them. Wait states are drawn at random on every access, so stalls also fall on the first and last word of a sequence.

// File: rtl/exc_frame_engine.sv
module exc_frame_engine #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TOKB = 4,
  parameter logic [DW-1:0] TOKEN = 32'hFFFF_FFF9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   entry_req,
  input  logic                   ret_req,
  input  logic [AW-1:0]          ret_target,
  input  logic [AW-1:0]          sp_in,
  input  logic [7:0][DW-1:0]     regs_in,
  output logic [7:0][DW-1:0]     regs_out,
  output logic [AW-1:0]          sp_out,
  output logic [DW-1:0]          lr_out,
  output logic                   busy,
  output logic                   done,
  output logic                   align_err,
  output logic                   mem_we,
  output logic                   mem_re,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  input  logic [DW-1:0]          mem_rdata,
  input  logic                   mem_ready
);
  localparam int NW = 8;
  localparam int CW = $clog2(NW);
  localparam logic [AW-1:0] FRAME = AW'(NW * (DW / 8));

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_POP} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] base;
  logic [NW-1:0][DW-1:0] frame;

  wire idle    = (st == S_IDLE);
  wire is_tok  = &ret_target[AW-1 -: TOKB];
  wire aligned = (sp_in[1:0] == 2'b00);
  wire go_push = idle && entry_req && aligned;
  wire go_pop  = idle && !entry_req && ret_req && is_tok && aligned;
  wire bad     = idle && !aligned && (entry_req || (ret_req && is_tok));
  wire [CW-1:0] slot = (st == S_PUSH) ? ~cnt : cnt;
  wire last    = mem_ready && (cnt == CW'(NW - 1));

  assign busy      = !idle;
  assign mem_we    = (st == S_PUSH);
  assign mem_re    = (st == S_POP);
  assign mem_addr  = base + AW'({slot, 2'b00});
  assign mem_wdata = frame[slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      base      <= '0;
      frame     <= '0;
      regs_out  <= '0;
      sp_out    <= '0;
      lr_out    <= '0;
      done      <= 1'b0;
      align_err <= 1'b0;
    end else begin
      done      <= 1'b0;
      align_err <= bad;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (go_push) begin
            st    <= S_PUSH;
            base  <= sp_in - FRAME;
            frame <= regs_in;
          end else if (go_pop) begin
            st   <= S_POP;
            base <= sp_in;
          end
        end
        S_PUSH: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          if (last) begin
            st     <= S_IDLE;
            done   <= 1'b1;
            sp_out <= base;
            lr_out <= TOKEN;
          end
        end
        S_POP: if (mem_ready) begin
          cnt <= cnt + 1'b1;
          regs_out[cnt] <= mem_rdata;
          if (last) begin
            st     <= S_IDLE;
            done   <= 1'b1;
            sp_out <= base + FRAME;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module exc_frame_engine_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          entry_req,
  input logic [AW-1:0] sp_in,
  input logic          busy,
  input logic          done,
  input logic          align_err,
  input logic          mem_we,
  input logic          mem_re,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);
  AST_ENTRY_FIRST_XPSR: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req && !busy && sp_in[1:0] == 2'b00 |=> busy && mem_we && mem_addr == $past(sp_in) - AW'(4)); // R3
  AST_WRITE_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_ready |=> !mem_we || mem_addr == $past(mem_addr) - AW'(4)); // R3
  AST_READ_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re && mem_ready |=> !mem_re || mem_addr == $past(mem_addr) + AW'(4)); // R5
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> mem_addr[1:0] == 2'b00); // R2
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) && !mem_ready |=> $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we) && $stable(mem_re)); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !busy && !mem_we && !mem_re); // R7
endmodule

bind exc_frame_engine exc_frame_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .sp_in(sp_in),
  .busy(busy), .done(done), .align_err(align_err), .mem_we(mem_we),
  .mem_re(mem_re), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/tb_exc_frame_engine.sv
module tb_exc_frame_engine;
  localparam int PERIOD = 10;
  localparam logic [31:0] TOKEN = 32'hFFFF_FFF9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic entry_req = 1'b0, ret_req = 1'b0, mem_ready = 1'b1;
  logic [31:0] ret_target = '0, sp_in = '0;
  logic [7:0][31:0] regs_in = '0;
  logic [7:0][31:0] regs_out;
  logic [31:0] sp_out, lr_out, mem_addr, mem_wdata, mem_rdata;
  logic busy, done, align_err, mem_we, mem_re;

  logic [31:0] mem [256];
  logic [31:0] wlog [16];
  logic [31:0] rlog [16];
  int wn = 0, rn = 0;
  int checks = 0, fails = 0;
  int cyc, stalls;
  bit busy_ok;
  bit rnd_ready = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  exc_frame_engine dut (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .ret_req(ret_req),
    .ret_target(ret_target), .sp_in(sp_in), .regs_in(regs_in), .regs_out(regs_out),
    .sp_out(sp_out), .lr_out(lr_out), .busy(busy), .done(done), .align_err(align_err),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  function automatic int widx(input logic [31:0] a);
    return int'(a[9:2]);
  endfunction

  assign mem_rdata = mem[widx(mem_addr)];

  always @(posedge clk) begin
    if (rst_n && mem_we && mem_ready) begin
      mem[widx(mem_addr)] = mem_wdata;
      if (wn < 16) wlog[wn] = mem_addr;
      wn++;
    end
    if (rst_n && mem_re && mem_ready) begin
      if (rn < 16) rlog[rn] = mem_addr;
      rn++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic run_seq();
    cyc = 0; stalls = 0; busy_ok = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      entry_req = 1'b0; ret_req = 1'b0;
      if (done) return;
      if (!busy) busy_ok = 1'b0;
      mem_ready = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
      if ((mem_we || mem_re) && !mem_ready) stalls++;
    end
    chk(1'b0, "watchdog R4", 32'(cyc), 32'd9);
  endtask

  task automatic do_entry(input logic [31:0] sp, input logic [7:0][31:0] r);
    wn = 0; rn = 0;
    sp_in = sp; regs_in = r; entry_req = 1'b1; mem_ready = 1'b1;
    run_seq();
    chk(wn == 8, "R1 write count", 32'(wn), 32'd8);
    chk(rn == 0, "R1 no reads", 32'(rn), 32'd0);
    for (int k = 0; k < 8; k++)
      chk(wlog[k] == sp - 32'd32 + 32'(4 * (7 - k)), "R3 write order", wlog[k], sp - 32'd32 + 32'(4 * (7 - k)));
    for (int s = 0; s < 8; s++)
      chk(mem[widx(sp - 32'd32 + 32'(4 * s))] == r[s], "R2 frame slot", mem[widx(sp - 32'd32 + 32'(4 * s))], r[s]);
    chk(cyc == 9 + stalls, "R4 R10 entry cycles", 32'(cyc), 32'(9 + stalls));
    chk(sp_out == sp - 32'd32, "R4 sp_out", sp_out, sp - 32'd32);
    chk(lr_out == TOKEN, "R4 lr token", lr_out, TOKEN);
    chk(busy_ok && !busy, "R8 busy span", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(!done, "R8 done pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic do_return(input logic [31:0] sp, input logic [31:0] tgt);
    logic [7:0][31:0] e;
    for (int s = 0; s < 8; s++) e[s] = mem[widx(sp + 32'(4 * s))];
    wn = 0; rn = 0;
    sp_in = sp; ret_target = tgt; ret_req = 1'b1; mem_ready = 1'b1;
    run_seq();
    chk(rn == 8 && wn == 0, "R5 read count", 32'(rn), 32'd8);
    for (int k = 0; k < 8; k++)
      chk(rlog[k] == sp + 32'(4 * k), "R5 read order", rlog[k], sp + 32'(4 * k));
    for (int s = 0; s < 8; s++)
      chk(regs_out[s] == e[s], "R5 restored slot", regs_out[s], e[s]);
    chk(sp_out == sp + 32'd32, "R5 sp_out", sp_out, sp + 32'd32);
    chk(cyc == 9 + stalls, "R10 return cycles", 32'(cyc), 32'(9 + stalls));
    @(negedge clk);
  endtask

  function automatic logic [7:0][31:0] rand_regs();
    logic [7:0][31:0] r;
    for (int s = 0; s < 8; s++) r[s] = $urandom;
    return r;
  endfunction

  initial begin
    #(PERIOD * 150000);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] sp, sp_keep;
    logic [7:0][31:0] r, keep;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !align_err && !mem_we && !mem_re && sp_out == 0 && lr_out == 0,
        "reset R8", sp_out, 32'd0);

    // R4: directed zero-wait entry, exact budget
    r = rand_regs();
    do_entry(32'h0000_0200, r);
    chk(cyc == 9, "R4 zero-wait budget", 32'(cyc), 32'd9);
    do_return(32'h0000_01E0, TOKEN);
    for (int s = 0; s < 8; s++) chk(regs_out[s] == r[s], "R5 round trip", regs_out[s], r[s]);

    // R6: ordinary returns are ignored
    keep = regs_out; sp_keep = sp_out;
    foreach (ret_target[i]) ;
    for (int t = 0; t < 2; t++) begin
      wn = 0; rn = 0;
      sp_in = 32'h100; ret_target = (t == 0) ? 32'h0000_1234 : 32'hEFFF_FFF9; ret_req = 1'b1;
      @(posedge clk); @(negedge clk); ret_req = 1'b0;
      chk(!busy, "R6 no busy", {31'd0, busy}, 32'd0);
      repeat (3) @(negedge clk);
      chk(wn == 0 && rn == 0 && !done, "R6 no access", 32'(wn + rn), 32'd0);
      chk(sp_out == sp_keep && regs_out == keep, "R6 state kept", sp_out, sp_keep);
    end

    // R7: unaligned stack pointer, entry and token return
    for (int t = 0; t < 2; t++) begin
      wn = 0; rn = 0;
      sp_in = 32'h0000_0102 + 32'(t);
      if (t == 0) entry_req = 1'b1; else begin ret_req = 1'b1; ret_target = TOKEN; end
      @(posedge clk); @(negedge clk); entry_req = 1'b0; ret_req = 1'b0;
      chk(align_err && !busy, "R7 error raised", {31'd0, align_err}, 32'd1);
      @(negedge clk);
      chk(!align_err, "R7 error one cycle", {31'd0, align_err}, 32'd0);
      chk(wn == 0 && rn == 0 && sp_out == sp_keep, "R7 no access", sp_out, sp_keep);
    end

    // R9: entry and token return in the same idle cycle
    r = rand_regs();
    ret_req = 1'b1; ret_target = TOKEN;
    do_entry(32'h0000_0300, r);

    // R9: requests while busy are ignored
    r = rand_regs();
    wn = 0; rn = 0;
    sp_in = 32'h0000_0380; regs_in = r; entry_req = 1'b1;
    @(posedge clk); @(negedge clk);
    entry_req = 1'b1; ret_req = 1'b1; ret_target = TOKEN; sp_in = 32'h40; regs_in = '0;
    @(posedge clk); @(negedge clk);
    entry_req = 1'b0; ret_req = 1'b0;
    while (!done) @(negedge clk);
    chk(wn == 8 && rn == 0, "R9 busy ignore count", 32'(wn), 32'd8);
    chk(sp_out == 32'h0000_0360, "R9 busy ignore sp", sp_out, 32'h0000_0360);
    for (int s = 0; s < 8; s++)
      chk(mem[widx(32'h360 + 32'(4 * s))] == r[s], "R9 frame intact", mem[widx(32'h360 + 32'(4 * s))], r[s]);
    @(negedge clk);

    // R10: random wait states and random frames, round trips
    rnd_ready = 1'b1;
    for (int it = 0; it < 30; it++) begin
      sp = 32'h40 + 32'(($urandom % 224) * 4);
      r = rand_regs();
      do_entry(sp, r);
      do_return(sp - 32'd32, TOKEN | 32'($urandom % 16));
      for (int s = 0; s < 8; s++) chk(regs_out[s] == r[s], "R10 round trip", regs_out[s], r[s]);
      chk(sp_out == sp, "R10 sp restored", sp_out, sp);
    end
    finish_run();
  end
endmodule